// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits beside a small cache and keeps track of which hardware thread contexts hold a load-linked reservation on which lines. Each line has one reservation bit per context, so several contexts may hold reservations on the same line at the same time. A load-linked request sets the requester's bit. A store to a line clears every bit on that line, whether the store is ordinary or conditional, and whether a conditional store succeeds or fails. An invalidation of a line also clears every bit on it.

Each store gets an answer one cycle after it is presented. The answer says whether the write may go ahead and, for a conditional store, whether it succeeded. Only a failing conditional store is held back. The cache data array, the tag lookup and any coherence traffic stay outside the block. The block only sees a line index and a context number for each request.

More than one request kind may arrive in the same cycle. Conflicts on the same line are settled by a fixed order: reset first, then invalidate, then store, then load-linked.

Top module: `llsc_monitor`

## Requirements
- R1: A load-linked request sets a reservation for (ll_line, ll_ctx). Repeating it from the same context leaves the state unchanged.
- R2: A conditional store succeeds only when st_ctx holds a reservation on st_line, judged after any invalidation presented in the same cycle.
- R3: For a conditional store, rsp_sc_result is 1 on success and 0 on failure. For an ordinary store, rsp_sc_result is 0.
- R4: After a conditional store, whether it succeeded or failed, no context holds a reservation on that line.
- R5: An ordinary store returns rsp_proceed = 1 and clears the reservations of every context on its line.
- R6: An invalidation clears all reservations on inv_line. Other lines are left alone.
- R7: rsp_proceed is 0 only in answer to a failing conditional store.
- R8: Synchronous active-high reset clears every reservation and rsp_valid.
- R9: rsp_valid, rsp_proceed and rsp_sc_result are registered. They answer the store presented in the previous cycle, and rsp_valid is 0 when no store was presented.
- R10: If a load-linked request and a store name the same line in the same cycle, the load-linked request is dropped.
- R11: If an invalidation and a load-linked request or a store name the same line in the same cycle, the invalidation acts first. The load-linked request is dropped, and a conditional store fails.
- R12: Reservations from different contexts on one line coexist. Requests on one line never change the reservations on another line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inv_valid | input | 1 | Invalidate request strobe |
| inv_line | input | LINE_W | Line to invalidate |
| st_valid | input | 1 | Store request strobe |
| st_line | input | LINE_W | Line written by the store |
| st_ctx | input | CTX_W | Context issuing the store |
| st_cond | input | 1 | 1 = conditional store, 0 = ordinary store |
| ll_valid | input | 1 | Load-linked request strobe |
| ll_line | input | LINE_W | Line read by the load-linked request |
| ll_ctx | input | CTX_W | Context issuing the load-linked request |
| rsp_valid | output | 1 | A store answer is present this cycle |
| rsp_proceed | output | 1 | The store may write |
| rsp_sc_result | output | 1 | Outcome of a conditional store (1 = success) |

## Verification
The hardest case to reach is a conditional store that finds its own reservation still present while other contexts also hold reservations on the same line. The case becomes harder still when an invalidation or a load-linked request for that line lands in the same cycle. Uniform random traffic seldom builds up several live reservations on one line before some store clears them. The stimulus therefore confines random traffic to a few lines and weights it heavily toward load-linked requests. Directed sequences then stack reservations from every context on one line and collide them with same-cycle invalidations and stores.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

   // Kind of answer held in the response stage
   typedef enum logic [1:0] {
      RSP_NONE    = 2'd0,
      RSP_PLAIN   = 2'd1,
      RSP_SC_OK   = 2'd2,
      RSP_SC_FAIL = 2'd3
   } llsc_rsp_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/llsc_decode.sv
module llsc_decode #(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic             en,
   input  logic [IDX_W-1:0] idx,
   output logic [N-1:0]     mask
);

   if (N < 1) begin : g_bad_n
      $error("llsc_decode: N must be at least 1");
   end
   if ((1 << IDX_W) < N) begin : g_bad_w
      $error("llsc_decode: IDX_W too narrow for N");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      assign mask[i] = en && (idx == IDX_W'(i));
   end

endmodule

// File: rtl/llsc_row.sv
module llsc_row #(
   parameter int NUM_CTX = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               inv_hit,
   input  logic               st_hit,
   input  logic               ll_hit,
   input  logic [NUM_CTX-1:0] ll_oh,
   output logic [NUM_CTX-1:0] rsv_q,
   output logic [NUM_CTX-1:0] rsv_eff
);

   logic [NUM_CTX-1:0] rsv_d;

   // Reservations that a store in this cycle may see (invalidate acts first)
   assign rsv_eff = inv_hit ? '0 : rsv_q;

   always_comb begin
      if (inv_hit || st_hit) rsv_d = '0;
      else if (ll_hit)       rsv_d = rsv_q | ll_oh;
      else                   rsv_d = rsv_q;
   end

   always_ff @(posedge clk) begin
      if (rst) rsv_q <= '0;
      else     rsv_q <= rsv_d;
   end

   // R1
   ll_sets_bit_chk: assert property (@(posedge clk) disable iff (rst)
      (ll_hit && !st_hit && !inv_hit) |=> ((rsv_q & $past(ll_oh)) == $past(ll_oh)));
   // R4
   store_clears_row_chk: assert property (@(posedge clk) disable iff (rst)
      st_hit |=> (rsv_q == '0));
   // R6
   inv_clears_row_chk: assert property (@(posedge clk) disable iff (rst)
      inv_hit |=> (rsv_q == '0));
   // R12
   idle_row_stable_chk: assert property (@(posedge clk) disable iff (rst)
      (!ll_hit && !st_hit && !inv_hit) |=> $stable(rsv_q));
   // R8
   reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (rsv_q == '0));

endmodule

// File: rtl/llsc_resp.sv
module llsc_resp
   import llsc_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic st_valid,
   input  logic st_cond,
   input  logic sc_hold,
   output logic rsp_valid,
   output logic rsp_proceed,
   output logic rsp_sc_result
);

   llsc_rsp_e kind_d, kind_q;

   always_comb begin
      if (!st_valid)    kind_d = RSP_NONE;
      else if (!st_cond) kind_d = RSP_PLAIN;
      else if (sc_hold) kind_d = RSP_SC_OK;
      else              kind_d = RSP_SC_FAIL;
   end

   always_ff @(posedge clk) begin
      if (rst) kind_q <= RSP_NONE;
      else     kind_q <= kind_d;
   end

   assign rsp_valid     = (kind_q != RSP_NONE);
   assign rsp_proceed   = (kind_q == RSP_PLAIN) || (kind_q == RSP_SC_OK);
   assign rsp_sc_result = (kind_q == RSP_SC_OK);

   // R3
   sc_ok_implies_go_chk: assert property (@(posedge clk) disable iff (rst)
      rsp_sc_result |-> (rsp_proceed && rsp_valid));
   // R9
   idle_no_answer_chk: assert property (@(posedge clk) disable iff (rst)
      !rsp_valid |-> (!rsp_proceed && !rsp_sc_result));

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
   import llsc_pkg::*;
#(
   parameter int NUM_LINES  = 8,
   parameter int NUM_CTX    = 4,
   localparam int LINE_W    = idx_width(NUM_LINES),
   localparam int CTX_W     = idx_width(NUM_CTX)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              inv_valid,
   input  logic [LINE_W-1:0] inv_line,
   input  logic              st_valid,
   input  logic [LINE_W-1:0] st_line,
   input  logic [CTX_W-1:0]  st_ctx,
   input  logic              st_cond,
   input  logic              ll_valid,
   input  logic [LINE_W-1:0] ll_line,
   input  logic [CTX_W-1:0]  ll_ctx,
   output logic              rsp_valid,
   output logic              rsp_proceed,
   output logic              rsp_sc_result
);

   if (NUM_LINES < 1 || NUM_LINES > 1024) begin : g_bad_lines
      $error("llsc_monitor: NUM_LINES out of range");
   end
   if (NUM_CTX < 1 || NUM_CTX > 64) begin : g_bad_ctx
      $error("llsc_monitor: NUM_CTX out of range");
   end

   logic [NUM_LINES-1:0] inv_mask, st_mask, ll_mask;
   logic [NUM_CTX-1:0]   ll_oh, st_oh;
   logic [NUM_LINES-1:0] line_hold;
   logic [NUM_CTX-1:0]   rsv_q   [NUM_LINES];
   logic [NUM_CTX-1:0]   rsv_eff [NUM_LINES];
   logic                 sc_hold;

   llsc_decode #(.N(NUM_LINES), .IDX_W(LINE_W)) u_inv_dec (
      .en(inv_valid), .idx(inv_line), .mask(inv_mask));
   llsc_decode #(.N(NUM_LINES), .IDX_W(LINE_W)) u_st_dec (
      .en(st_valid), .idx(st_line), .mask(st_mask));
   llsc_decode #(.N(NUM_LINES), .IDX_W(LINE_W)) u_ll_dec (
      .en(ll_valid), .idx(ll_line), .mask(ll_mask));
   llsc_decode #(.N(NUM_CTX), .IDX_W(CTX_W)) u_llctx_dec (
      .en(1'b1), .idx(ll_ctx), .mask(ll_oh));
   llsc_decode #(.N(NUM_CTX), .IDX_W(CTX_W)) u_stctx_dec (
      .en(1'b1), .idx(st_ctx), .mask(st_oh));

   for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      llsc_row #(.NUM_CTX(NUM_CTX)) u_row (
         .clk     (clk),
         .rst     (rst),
         .inv_hit (inv_mask[l]),
         .st_hit  (st_mask[l]),
         .ll_hit  (ll_mask[l]),
         .ll_oh   (ll_oh),
         .rsv_q   (rsv_q[l]),
         .rsv_eff (rsv_eff[l]));
      assign line_hold[l] = st_mask[l] && |(rsv_eff[l] & st_oh);
   end

   assign sc_hold = |line_hold;

   llsc_resp u_resp (
      .clk           (clk),
      .rst           (rst),
      .st_valid      (st_valid),
      .st_cond       (st_cond),
      .sc_hold       (sc_hold),
      .rsp_valid     (rsp_valid),
      .rsp_proceed   (rsp_proceed),
      .rsp_sc_result (rsp_sc_result));

   logic armed_q;
   always_ff @(posedge clk) begin
      if (rst) armed_q <= 1'b0;
      else     armed_q <= 1'b1;
   end

   // R9
   onehot_line_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(st_mask) && $onehot0(ll_mask) && $onehot0(inv_mask));
   // R7
   plain_store_goes_chk: assert property (@(posedge clk) disable iff (rst)
      (armed_q && $past(st_valid && !st_cond)) |-> (rsp_valid && rsp_proceed && !rsp_sc_result));
   // R9
   answer_follows_store_chk: assert property (@(posedge clk) disable iff (rst)
      armed_q |-> (rsp_valid == $past(st_valid)));
   // R11
   inv_beats_sc_chk: assert property (@(posedge clk) disable iff (rst)
      (armed_q && $past(st_valid && st_cond && inv_valid && inv_line == st_line))
         |-> (rsp_valid && !rsp_proceed));

endmodule

// File: tb/tb_llsc_monitor.sv
`timescale 1ns/1ps
module tb_llsc_monitor;
   localparam int NL = 8;
   localparam int NC = 4;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic inv_valid = 0, st_valid = 0, st_cond = 0, ll_valid = 0;
   logic [2:0] inv_line = 0, st_line = 0, ll_line = 0;
   logic [1:0] st_ctx = 0, ll_ctx = 0;
   logic rsp_valid, rsp_proceed, rsp_sc_result;

   int tests = 0, fails = 0;
   bit done = 0;
   bit model [NL][NC];

   always #2.5 clk = ~clk;

   llsc_monitor #(.NUM_LINES(NL), .NUM_CTX(NC)) dut (
      .clk(clk), .rst(rst),
      .inv_valid(inv_valid), .inv_line(inv_line),
      .st_valid(st_valid), .st_line(st_line), .st_ctx(st_ctx), .st_cond(st_cond),
      .ll_valid(ll_valid), .ll_line(ll_line), .ll_ctx(ll_ctx),
      .rsp_valid(rsp_valid), .rsp_proceed(rsp_proceed), .rsp_sc_result(rsp_sc_result));

   task automatic check(input string req, input logic act, input logic exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit exp_success();
      if (!st_valid || !st_cond) return 0;
      if (inv_valid && inv_line == st_line) return 0;
      return model[st_line][st_ctx];
   endfunction

   function automatic void model_update();
      if (inv_valid) for (int c = 0; c < NC; c++) model[inv_line][c] = 0;
      if (st_valid)  for (int c = 0; c < NC; c++) model[st_line][c] = 0;
      if (ll_valid && !(st_valid && st_line == ll_line)
                   && !(inv_valid && inv_line == ll_line))
         model[ll_line][ll_ctx] = 1;
   endfunction

   // Apply the current inputs for one cycle and check the answer one cycle later
   task automatic step(input string req);
      bit ok, sv, sc;
      ok = exp_success();
      sv = st_valid;
      sc = st_cond;
      model_update();
      @(posedge clk);
      @(negedge clk);
      check({req, " R9 valid"}, rsp_valid, sv);
      check({req, " R7 proceed"}, rsp_proceed, sv && (!sc || ok));
      check({req, " R3 result"}, rsp_sc_result, sv && sc && ok);
      inv_valid = 0; st_valid = 0; ll_valid = 0; st_cond = 0;
   endtask

   task automatic do_ll(input int l, input int c);
      ll_valid = 1; ll_line = 3'(l); ll_ctx = 2'(c);
   endtask
   task automatic do_st(input int l, input int c, input bit cond);
      st_valid = 1; st_line = 3'(l); st_ctx = 2'(c); st_cond = cond;
   endtask
   task automatic do_inv(input int l);
      inv_valid = 1; inv_line = 3'(l);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         fails++; tests++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = 32'h5eed_1234;
      void'($urandom(seed));
      for (int l = 0; l < NL; l++) for (int c = 0; c < NC; c++) model[l][c] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R8 reset valid", rsp_valid, 1'b0);
      rst = 0;

      // R8: nothing reserved after reset, every SC fails
      for (int c = 0; c < NC; c++) begin do_st(2, c, 1); step("R8 empty"); end

      // R1 + R12: all contexts on line 1, repeated LL harmless
      for (int c = 0; c < NC; c++) begin do_ll(1, c); step("R1 ll"); end
      do_ll(1, 2); step("R1 repeat");
      do_ll(5, 0); step("R12 other line");
      do_st(1, 3, 1); step("R2 sc ok");
      // R4: others cleared by that SC
      do_st(1, 0, 1); step("R4 after sc");
      // R12: line 5 untouched
      do_st(5, 0, 1); step("R12 line5");

      // R4 failing SC also clears
      do_ll(3, 1); step("R1 ll");
      do_st(3, 2, 1); step("R4 fail sc");
      do_st(3, 1, 1); step("R4 cleared");

      // R5 plain store clears
      do_ll(4, 0); step("R1 ll");
      do_ll(4, 3); step("R1 ll");
      do_st(4, 2, 0); step("R5 plain");
      do_st(4, 0, 1); step("R5 cleared");

      // R6 invalidate, other line kept
      do_ll(6, 1); step("R1 ll");
      do_ll(7, 1); step("R1 ll");
      do_inv(6); step("R6 inv");
      do_st(6, 1, 1); step("R6 cleared");
      do_st(7, 1, 1); step("R6 other kept");

      // R10 LL and store same line
      do_ll(2, 0); do_st(2, 1, 0); step("R10 collide");
      do_st(2, 0, 1); step("R10 dropped");
      // LL on a different line from a store is kept
      do_ll(0, 2); do_st(2, 1, 0); step("R12 split");
      do_st(0, 2, 1); step("R12 kept");

      // R11 invalidate vs SC and vs LL
      do_ll(5, 3); step("R1 ll");
      do_inv(5); do_st(5, 3, 1); step("R11 inv sc");
      do_inv(1); do_ll(1, 0); step("R11 inv ll");
      do_st(1, 0, 1); step("R11 ll dropped");

      // Random traffic on a few lines, LL-heavy
      for (int i = 0; i < 4000; i++) begin
         int r;
         r = $urandom_range(0, 99);
         if (r < 55) do_ll($urandom_range(0, 2), $urandom_range(0, NC-1));
         if ($urandom_range(0, 99) < 35)
            do_st($urandom_range(0, 2), $urandom_range(0, NC-1), $urandom_range(0, 3) != 0);
         if ($urandom_range(0, 99) < 8) do_inv($urandom_range(0, 2));
         step("R2 random");
      end

      // R8 mid-run reset wipes reservations
      do_ll(0, 0); step("R1 ll");
      rst = 1; @(posedge clk); @(negedge clk); rst = 0;
      for (int l = 0; l < NL; l++) for (int c = 0; c < NC; c++) model[l][c] = 0;
      check("R8 reset valid", rsp_valid, 1'b0);
      do_st(0, 0, 1); step("R8 wiped");

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule